// File: doc/BRIEF.md
# Converter Serial Result Transmitter

This block is the digital read port of a sampling converter. It keeps conversion results in two registers and shifts one of them out, most significant bit first, on a data clock that an outside receiver drives in bursts. The data clock is slow compared with the block's system clock. It is brought in through a short synchronizer, and both of its edges are detected inside the block. Each falling edge of the data clock advances the frame by one bit. Each value stays on the line through the following rising edge, so the receiver may capture on either edge.

A read window is open while `cs_n` is low and `rd_cnv` is high. A data-clock edge that arrives while the window is closed arms a one-bit sync marker. The next frame then begins with that marker and moves its data one pulse later. The analog part of the converter is not modelled. Each finished result arrives through a strobed load port, and the `busy` input reports whether a conversion is in progress (`busy` is low while converting).

If a result arrives while a frame is being shifted, the block parks it and stores it only after the frame has finished. The word on the line is therefore never mixed from two results.

Top module: `conv_serial_tx`

## Requirements
- R1: While reset is held and just after it, `sdo` and `sync_out` are low and both stored results are zero, so a first read shifts out all zeros.
- R2: Whenever the read window is closed (`cs_n` high or `rd_cnv` low), `sdo` and `sync_out` are low from the next system clock on.
- R3: A data-clock edge of either polarity, detected while the window is closed, arms the sync marker. The next frame uses the armed state and clears it, so a later frame with no new edge outside the window is unarmed.
- R4: In an unarmed frame, after falling data-clock edge k (k = 1..16) `sdo` carries result bit 16-k, and `sync_out` stays low.
- R5: In an armed frame, `sync_out` is high with `sdo` low after falling edge 1. After falling edge k (k = 2..17) `sdo` carries result bit 17-k and `sync_out` is low.
- R6: Both outputs hold their value from one detected falling edge until the next one, including across the rising edge between them.
- R7: The falling edge after the last bit (edge 17 unarmed, edge 18 armed) drives `sdo` low and ends the frame. Further pulses in the same window leave both outputs low. Closing the window part way through aborts the frame, and the next window starts again from its first bit.
- R8: The source word is chosen at a frame's first falling edge. With `busy` high it is the latest loaded result. With `busy` low it is the result that was latest when `busy` last fell, even if a newer result has been loaded since.
- R9: A load that arrives during a frame, including on its first falling edge, does not change the word being shifted. The load takes effect once the frame ends or is aborted.
- R10: A load outside a frame replaces the latest result at once. The copy read during a conversion changes only on a falling edge of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select |
| rd_cnv | input | 1 | High selects read, low selects convert |
| sclk_in | input | 1 | External discontinuous data clock, idles high |
| busy | input | 1 | Low while a conversion runs, high when it is done |
| load_stb | input | 1 | One-cycle strobe carrying a finished result |
| load_word | input | WORD_W | Finished result that goes with `load_stb` |
| sdo | output | 1 | Serial data, MSB first |
| sync_out | output | 1 | One-bit sync marker that comes before the data in an armed frame |

## Verification
Two functions can fall in the same system clock: a result load and the falling edge that opens or advances a frame. The bench drives `load_stb` in exactly the cycle in which the synchronized falling edge reaches the sequencer. It does this at the first pulse of a frame and at random pulses later in the frame. Each frame is judged bit by bit against the word the bench model chose at frame start. The next read is then judged against the parked word, which shows the load took effect only after the frame.

// File: rtl/conv_serial_pkg.sv
package conv_serial_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } frame_st_e;

  // falling-edge number that carries the least significant bit
  function automatic int last_bit_edge(int width, logic lead);
    return width + int'(lead);
  endfunction

  // result bit presented after falling edge k of a frame
  function automatic int bit_pos(int width, logic lead, int k);
    return width + int'(lead) - k;
  endfunction

endpackage

// File: rtl/dclk_edge_det.sv
module dclk_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic edge_any,
  output logic edge_fall
);
  logic [STAGES:0] sh_q;

  // the reset value matches the idle-high level, so no edge appears when reset ends
  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], sclk_in};
  end

  assign edge_any  = sh_q[STAGES] ^ sh_q[STAGES-1];
  assign edge_fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         load_stb,
  input  logic [W-1:0] load_word,
  input  logic         hold,
  output logic [W-1:0] fresh_w,
  output logic [W-1:0] held_w
);
  logic [W-1:0] fresh_q, held_q, park_q;
  logic         park_v_q, busy_q;
  logic         busy_fall, load_park, park_apply;

  assign busy_fall  = busy_q & ~busy;
  assign load_park  = load_stb & hold;
  assign park_apply = park_v_q & ~hold & ~load_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh_q  <= '0;
      held_q   <= '0;
      park_q   <= '0;
      park_v_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy_fall) held_q <= fresh_q;
      if (load_park) begin
        park_q   <= load_word;
        park_v_q <= 1'b1;
      end else if (load_stb) begin
        fresh_q  <= load_word;
        park_v_q <= 1'b0;
      end else if (park_apply) begin
        fresh_q  <= park_q;
        park_v_q <= 1'b0;
      end
    end
  end

  assign fresh_w = fresh_q;
  assign held_w  = held_q;

  // R9: latest result frozen while a frame uses the bank
  assert_word_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(fresh_q));
  // R9: a parked load is released as soon as the frame is over
  assert_park_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (park_v_q && !hold) |=> !park_v_q);
  // R10: the conversion-time copy only moves on a busy fall
  assert_held_only_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_fall |=> $stable(held_q));
  // R10: a load outside a frame lands immediately
  assert_direct_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !hold) |=> (fresh_q == $past(load_word)));
endmodule

// File: rtl/serial_framer.sv
module serial_framer
  import conv_serial_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_cnv,
  input  logic         busy,
  input  logic         clk_edge,
  input  logic         clk_fall,
  input  logic [W-1:0] fresh_w,
  input  logic [W-1:0] held_w,
  output logic         sdo,
  output logic         sync_out,
  output logic         bank_hold
);
  localparam int CNT_W = $clog2(W + 3);
  localparam int IDX_W = $clog2(W);

  frame_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, lead_q, sel_q, sdo_q, sync_q;

  logic             win_open, frame_start, frame_on;
  logic [CNT_W-1:0] k_nxt;
  logic [W-1:0]     src_w;
  logic [IDX_W-1:0] idx_w;
  logic             last_passed;

  assign win_open    = !cs_n && rd_cnv;
  assign frame_start = win_open && clk_fall && (st_q == FR_IDLE);
  assign frame_on    = (st_q == FR_SHIFT);
  assign bank_hold   = frame_on || frame_start;

  assign k_nxt       = cnt_q + CNT_W'(1);
  assign last_passed = int'(k_nxt) > last_bit_edge(W, lead_q);
  assign idx_w       = IDX_W'(bit_pos(W, lead_q, int'(k_nxt)));
  assign src_w       = (st_q == FR_IDLE) ? (busy ? fresh_w : held_w)
                                         : (sel_q ? fresh_w : held_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= FR_IDLE;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      lead_q  <= 1'b0;
      sel_q   <= 1'b0;
      sdo_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else if (!win_open) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      sync_q <= 1'b0;
      if (clk_edge) armed_q <= 1'b1;
    end else if (clk_fall) begin
      unique case (st_q)
        FR_IDLE: begin
          st_q    <= FR_SHIFT;
          cnt_q   <= CNT_W'(1);
          lead_q  <= armed_q;
          armed_q <= 1'b0;
          sel_q   <= busy;
          sync_q  <= armed_q;
          sdo_q   <= armed_q ? 1'b0 : src_w[W-1];
        end
        FR_SHIFT: begin
          sync_q <= 1'b0;
          if (last_passed) begin
            st_q  <= FR_DONE;
            cnt_q <= '0;
            sdo_q <= 1'b0;
          end else begin
            cnt_q <= k_nxt;
            sdo_q <= src_w[idx_w];
          end
        end
        default: begin
          sdo_q  <= 1'b0;
          sync_q <= 1'b0;
        end
      endcase
    end
  end

  assign sdo      = sdo_q;
  assign sync_out = sync_q;

  // R2: a closed window silences both outputs on the next clock
  assert_quiet_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> (!sdo && !sync_out));
  // R3: the marker appears only in a frame that started armed
  assert_sync_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> lead_q);
  // R5: marker slot carries no data bit
  assert_sync_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> !sdo);
  // R6: outputs move only after a detected falling edge or a window change
  assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && $past(win_open) && !$past(clk_fall)) |-> ($stable(sdo) && $stable(sync_out)));
  // R7: a finished frame stays low and its counter is cleared
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_DONE) |-> (!sdo && !sync_out && cnt_q == '0));
  // R7: the counter never passes the end-of-frame edge
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= W + 1);
endmodule

// File: rtl/conv_serial_tx.sv
module conv_serial_tx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_cnv,
  input  logic              sclk_in,
  input  logic              busy,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] load_word,
  output logic              sdo,
  output logic              sync_out
);
  logic              dclk_edge, dclk_fall, bank_hold;
  logic [WORD_W-1:0] fresh_w, held_w;

  dclk_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_in   (sclk_in),
    .edge_any  (dclk_edge),
    .edge_fall (dclk_fall)
  );

  result_bank #(.W(WORD_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .load_stb  (load_stb),
    .load_word (load_word),
    .hold      (bank_hold),
    .fresh_w   (fresh_w),
    .held_w    (held_w)
  );

  serial_framer #(.W(WORD_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_cnv    (rd_cnv),
    .busy      (busy),
    .clk_edge  (dclk_edge),
    .clk_fall  (dclk_fall),
    .fresh_w   (fresh_w),
    .held_w    (held_w),
    .sdo       (sdo),
    .sync_out  (sync_out),
    .bank_hold (bank_hold)
  );
endmodule

// File: tb/tb_conv_serial_tx.sv
module tb_conv_serial_tx;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         rd_cnv = 1'b0;
  logic         sclk = 1'b1;
  logic         busy = 1'b1;
  logic         load_stb = 1'b0;
  logic [W-1:0] load_word = '0;
  logic         sdo, sync_out;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] fresh_m = '0, held_m = '0, park_m = '0;
  bit           park_v = 1'b0;

  always #5 clk = ~clk;

  conv_serial_tx #(.WORD_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv), .sclk_in(sclk),
    .busy(busy), .load_stb(load_stb), .load_word(load_word),
    .sdo(sdo), .sync_out(sync_out)
  );

  // expected {sync, sdo} after falling edge k
  function automatic logic [1:0] exp_out(int k, bit armed, logic [W-1:0] w);
    int lead = armed ? 1 : 0;
    if (armed && k == 1) return 2'b10;
    if (k > lead && k <= W + lead) return {1'b0, w[W + lead - k]};
    return 2'b00;
  endfunction

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic model_load(logic [W-1:0] w, bit in_frame);
    if (in_frame) begin park_m = w; park_v = 1'b1; end
    else begin fresh_m = w; park_v = 1'b0; end
  endtask

  task automatic model_release();
    if (park_v) fresh_m = park_m;
    park_v = 1'b0;
  endtask

  // one data-clock pulse; optional load in the cycle the fall reaches the sequencer
  task automatic dpulse(bit do_load, logic [W-1:0] lw,
                        output logic [1:0] s_fall, output logic [1:0] s_hold);
    sclk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (do_load) begin load_stb = 1'b1; load_word = lw; end
    @(negedge clk);
    load_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    s_fall = {sync_out, sdo};
    sclk = 1'b1;
    repeat (6) @(negedge clk);
    s_hold = {sync_out, sdo};
  endtask

  task automatic arm_pulse(bit via_cs);
    logic [1:0] a, b;
    if (via_cs) begin cs_n = 1'b1; rd_cnv = 1'b1; end
    else        begin cs_n = 1'b0; rd_cnv = 1'b0; end
    repeat (2) @(negedge clk);
    dpulse(1'b0, '0, a, b);
    cs_n = 1'b0; rd_cnv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(bit armed, bit via_cs, int npulse, int abort_at,
                         int load_at, logic [W-1:0] lw, string tag);
    logic [W-1:0] w;
    logic [1:0]   sf, sh, e;
    int           endk;
    string        tg;
    if (armed) arm_pulse(via_cs);
    w    = busy ? fresh_m : held_m;
    endk = W + 1 + (armed ? 1 : 0);
    cs_n = 1'b0; rd_cnv = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 1; k <= npulse; k++) begin
      dpulse(k == load_at, lw, sf, sh);
      if (k == load_at) model_load(lw, k <= endk);
      e = exp_out(k, armed, w);
      if (tag != "")      tg = tag;
      else if (k >= endk) tg = "R7";
      else if (armed && k == 1) tg = "R3";
      else                tg = armed ? "R5" : "R4";
      chk(sf == e, tg, W'(sf), W'(e));
      chk(sh == e, "R6", W'(sh), W'(e));
      if (k == endk) model_release();
      if (k == abort_at) break;
    end
    rd_cnv = 1'b0;
    repeat (2) @(negedge clk);
    chk({sync_out, sdo} == 2'b00, "R2", W'({sync_out, sdo}), '0);
    model_release();
    repeat (2) @(negedge clk);
  endtask

  task automatic start_conv();
    busy = 1'b0;
    held_m = fresh_m;
    repeat (3) @(negedge clk);
  endtask

  task automatic land(logic [W-1:0] w);
    load_stb = 1'b1; load_word = w;
    @(negedge clk);
    load_stb = 1'b0;
    model_load(w, 1'b0);
    @(negedge clk);
  endtask

  task automatic end_conv();
    busy = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int unsigned seed = 32'h5eed_c0de;
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    chk({sync_out, sdo} == 2'b00, "R1", W'({sync_out, sdo}), '0);
    rst_n = 1'b1;
    cs_n = 1'b0; rd_cnv = 1'b0;
    repeat (3) @(negedge clk);
    chk({sync_out, sdo} == 2'b00, "R1", W'({sync_out, sdo}), '0);
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R1");

    land(16'hA5C3);
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R10");
    do_read(1'b1, 1'b1, W + 2, 0, 0, '0, "");
    do_read(1'b1, 1'b0, W + 2, 0, 0, '0, "R5");
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R3");

    start_conv();
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R8");
    land(16'h3C5A);
    do_read(1'b1, 1'b1, W + 2, 0, 0, '0, "R8");
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R10");
    end_conv();
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R8");

    do_read(1'b0, 1'b0, W + 1, 0, 1, 16'hF00F, "R9");
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R9");
    do_read(1'b1, 1'b0, W + 2, 0, 8, 16'h1234, "R9");
    do_read(1'b1, 1'b0, W + 2, 0, 0, '0, "R9");

    do_read(1'b0, 1'b0, W + 4, 0, 0, '0, "");
    do_read(1'b0, 1'b0, 5, 5, 3, 16'h8001, "");
    do_read(1'b0, 1'b0, W + 1, 0, 0, '0, "R7");

    for (int it = 0; it < 40; it++) begin
      int act = $urandom_range(0, 3);
      logic [W-1:0] rw = W'($urandom);
      bit arm = 1'(($urandom));
      bit vcs = 1'(($urandom));
      int ld  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, W + 3)) : 0;
      int ab  = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, W)) : 0;
      case (act)
        0: begin if (busy) start_conv(); else begin land(rw); end_conv(); end end
        1: if (!busy) land(rw); else land(rw);
        default: do_read(arm, vcs, W + 1 + (arm ? 1 : 0) + int'($urandom_range(0, 2)),
                         ab, ld, rw, "");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule